// File: doc/BRIEF.md
# Line and Field Sync Timer

This block keeps the pixel position within a line and the line position within a field for an image sensor front end. A horizontal counter advances once per master clock and a vertical counter advances once per line. The line length and the length of the final line of each field arrive as Gray-coded configuration words, both offset so that the programmed value is four less than the number of clocks in the line. A binary input gives the index of the last line of a field.

Out of reset the block follows externally supplied horizontal and vertical sync. A rising edge on the horizontal input restarts the line, and a rising edge on the vertical input restarts the field. Both inputs pass through a two-flop synchronizer before edge detection. With the mode input set to source, the block drives its own horizontal and vertical sync outputs from its counters. A synchronous realign strobe zeroes both counters at any time.

Configuration and mode are captured only at line boundaries, so a change never cuts a line short.

Top module: `line_field_timer`

## Requirements
- R1: While reset is held and right after it, both counters read 0, the block is in follower mode, and both sync outputs are low.
- R2: Each configuration length word is Gray-coded: binary bit i is the XOR of Gray bits i and above. For example 0x51E decodes to 1556.
- R3: In source mode the horizontal count runs from 0 up to the decoded line length plus 3 and then returns to 0, so a line takes length+4 clocks. If that limit cannot be represented, the count wraps at its all-ones value.
- R4: The line whose vertical index equals the last-line index uses the decoded last-line length (last+4 clocks) in place of the normal length.
- R5: In source mode the vertical count increments at every line end and returns to 0 after the line whose index equals the last-line index.
- R6: In source mode the horizontal sync output is high while the horizontal count is below HD_WIDTH, and the vertical sync output is high while the vertical count is 0.
- R7: The clock edge that samples the realign strobe high sets both counters to 0 and captures the configuration and mode inputs.
- R8: In follower mode both sync outputs stay low.
- R9: In follower mode, the third clock edge after the horizontal sync input rises sets the horizontal count to 0 and advances the vertical count by one. A level held high does not retrigger.
- R10: In follower mode, the third clock edge after the vertical sync input rises sets the vertical count to 0 and leaves the horizontal count running.
- R11: Length words and the last-line index are captured only at a line end, on a realign, or on a follower-mode horizontal edge. A change in mid-line leaves the current line's length as it was.
- R12: The mode input (1 = source, 0 = follower) is captured only at the same boundaries as in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_src_i | input | 1 | 1 selects source mode, 0 selects follower mode |
| realign_i | input | 1 | Synchronous strobe that zeroes both counters |
| hsync_i | input | 1 | External horizontal sync (follower mode) |
| vsync_i | input | 1 | External vertical sync (follower mode) |
| line_len_gray_i | input | H_W | Gray-coded line length minus 4 |
| last_len_gray_i | input | H_W | Gray-coded last-line length minus 4 |
| last_line_i | input | V_W | Index of the last line of a field (binary) |
| hsync_o | output | 1 | Generated horizontal sync |
| vsync_o | output | 1 | Generated vertical sync |
| h_count_o | output | H_W | Horizontal pixel count |
| v_count_o | output | V_W | Vertical line count |

## Verification
The bench builds the block with H_W = 12, V_W = 4 and HD_WIDTH = 3. The 4-bit vertical count and a 3-clock sync pulse make whole fields only a few dozen clocks long. As a result, every combination of line setting 0..9, three last-line settings and last-line index 0..2 is run over two complete fields, with every clock compared against a position computed from the cycle number. The full 12-bit horizontal width is kept, so the 1560-clock line programmed as Gray 0x51E also runs end to end.

// File: rtl/lft_pkg.sv
package lft_pkg;

  typedef enum logic {
    MODE_FOLLOW = 1'b0,
    MODE_SOURCE = 1'b1
  } lft_mode_e;

  localparam int unsigned LFT_SYNC_STAGES = 2;

endpackage

// File: rtl/lft_gray2bin.sv
module lft_gray2bin #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);

  // Each binary bit is the parity of the Gray bits at and above it.
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign bin_o[i] = ^gray_i[W-1:i];
    end
  endgenerate

endmodule

// File: rtl/lft_sync_edge.sv
module lft_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/lft_cfg_reg.sv
module lft_cfg_reg #(
  parameter int unsigned H_W = 12,
  parameter int unsigned V_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              mode_src_i,
  input  logic [H_W-1:0]    line_gray_i,
  input  logic [H_W-1:0]    last_gray_i,
  input  logic [V_W-1:0]    last_line_i,
  output lft_pkg::lft_mode_e mode_o,
  output logic [H_W-1:0]    line_len_o,
  output logic [H_W-1:0]    last_len_o,
  output logic [V_W-1:0]    last_line_o
);

  logic [H_W-1:0] line_bin, last_bin;

  lft_gray2bin #(.W(H_W)) u_dec_line (.gray_i(line_gray_i), .bin_o(line_bin));
  lft_gray2bin #(.W(H_W)) u_dec_last (.gray_i(last_gray_i), .bin_o(last_bin));

  lft_pkg::lft_mode_e mode_d;
  logic [H_W-1:0]     line_d, last_d;
  logic [V_W-1:0]     lline_d;

  always_comb begin
    mode_d  = mode_o;
    line_d  = line_len_o;
    last_d  = last_len_o;
    lline_d = last_line_o;
    if (load_i) begin
      mode_d  = mode_src_i ? lft_pkg::MODE_SOURCE : lft_pkg::MODE_FOLLOW;
      line_d  = line_bin;
      last_d  = last_bin;
      lline_d = last_line_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o      <= lft_pkg::MODE_FOLLOW;
      line_len_o  <= '0;
      last_len_o  <= '0;
      last_line_o <= '0;
    end else begin
      mode_o      <= mode_d;
      line_len_o  <= line_d;
      last_len_o  <= last_d;
      last_line_o <= lline_d;
    end
  end

endmodule

// File: rtl/line_field_timer.sv
module line_field_timer #(
  parameter int unsigned H_W      = 12,
  parameter int unsigned V_W      = 11,
  parameter int unsigned HD_WIDTH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_src_i,
  input  logic           realign_i,
  input  logic           hsync_i,
  input  logic           vsync_i,
  input  logic [H_W-1:0] line_len_gray_i,
  input  logic [H_W-1:0] last_len_gray_i,
  input  logic [V_W-1:0] last_line_i,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic [H_W-1:0] h_count_o,
  output logic [V_W-1:0] v_count_o
);

  localparam int unsigned    LIM_W  = H_W + 1;
  localparam logic [LIM_W-1:0] PAD  = LIM_W'(3);
  localparam logic [LIM_W-1:0] HD_LIM = LIM_W'(HD_WIDTH);
  localparam logic [H_W-1:0] H_ONE  = H_W'(1);
  localparam logic [H_W-1:0] H_MAX  = {H_W{1'b1}};
  localparam logic [V_W-1:0] V_ONE  = V_W'(1);

  lft_pkg::lft_mode_e cfg_mode;
  logic [H_W-1:0]     cfg_len, cfg_last;
  logic [V_W-1:0]     cfg_lline;
  logic               hd_rise, vd_rise;
  logic               is_master;
  logic [H_W-1:0]     sel_len;
  logic [LIM_W-1:0]   h_limit;
  logic               h_end, cfg_load;
  logic [H_W-1:0]     h_q, h_d;
  logic [V_W-1:0]     v_q, v_d;

  lft_sync_edge #(.STAGES(lft_pkg::LFT_SYNC_STAGES)) u_hs (
    .clk(clk), .rst_n(rst_n), .async_i(hsync_i), .rise_o(hd_rise));
  lft_sync_edge #(.STAGES(lft_pkg::LFT_SYNC_STAGES)) u_vs (
    .clk(clk), .rst_n(rst_n), .async_i(vsync_i), .rise_o(vd_rise));

  lft_cfg_reg #(.H_W(H_W), .V_W(V_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_i(cfg_load), .mode_src_i(mode_src_i),
    .line_gray_i(line_len_gray_i), .last_gray_i(last_len_gray_i),
    .last_line_i(last_line_i), .mode_o(cfg_mode), .line_len_o(cfg_len),
    .last_len_o(cfg_last), .last_line_o(cfg_lline));

  assign is_master = (cfg_mode == lft_pkg::MODE_SOURCE);

  // Line limit: final line of the field takes the last-line length.
  always_comb begin
    sel_len  = (v_q == cfg_lline) ? cfg_last : cfg_len;
    h_limit  = {1'b0, sel_len} + PAD;
    h_end    = ({1'b0, h_q} == h_limit) || (h_q == H_MAX);
    cfg_load = realign_i || h_end || (!is_master && hd_rise);
  end

  // Counter next state.
  always_comb begin
    h_d = h_q;
    v_d = v_q;
    if (realign_i) begin
      h_d = '0;
      v_d = '0;
    end else if (is_master) begin
      if (h_end) begin
        h_d = '0;
        v_d = (v_q >= cfg_lline) ? '0 : v_q + V_ONE;
      end else begin
        h_d = h_q + H_ONE;
      end
    end else begin
      h_d = (hd_rise || h_end) ? '0 : h_q + H_ONE;
      if (vd_rise)      v_d = '0;
      else if (hd_rise) v_d = v_q + V_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign hsync_o   = is_master && ({1'b0, h_q} < HD_LIM);
  assign vsync_o   = is_master && (v_q == '0);
  assign h_count_o = h_q;
  assign v_count_o = v_q;

endmodule

// File: rtl/line_field_timer_chk.sv
module line_field_timer_chk #(
  parameter int unsigned H_W = 12,
  parameter int unsigned V_W = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           realign_i,
  input logic           is_master,
  input logic           hd_rise,
  input logic [H_W:0]   h_limit,
  input logic [H_W-1:0] cfg_len,
  input logic           hsync_o,
  input logic           vsync_o,
  input logic [H_W-1:0] h_count_o,
  input logic [V_W-1:0] v_count_o
);

  localparam logic [H_W-1:0] C_ONE = H_W'(1);
  localparam logic [H_W-1:0] C_MAX = {H_W{1'b1}};

  assert_realign_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    realign_i |=> (h_count_o == '0 && v_count_o == '0));

  assert_h_within_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> ({1'b0, h_count_o} <= h_limit));

  assert_h_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !realign_i && ({1'b0, h_count_o} != h_limit) && h_count_o != C_MAX)
    |=> h_count_o == $past(h_count_o) + C_ONE);

  assert_hsync_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_o) |-> h_count_o == '0);

  assert_vsync_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_o) |-> (h_count_o == '0 && v_count_o == '0));

  assert_follow_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && hd_rise && !realign_i) |=> h_count_o == '0);

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (h_count_o != '0) |-> $stable(cfg_len));

endmodule

bind line_field_timer line_field_timer_chk #(.H_W(H_W), .V_W(V_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .realign_i(realign_i), .is_master(is_master),
  .hd_rise(hd_rise), .h_limit(h_limit), .cfg_len(cfg_len),
  .hsync_o(hsync_o), .vsync_o(vsync_o), .h_count_o(h_count_o),
  .v_count_o(v_count_o));

// File: tb/line_field_timer_tb.sv
module line_field_timer_tb;

  localparam int H_W = 12;
  localparam int V_W = 4;
  localparam int HDW = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           mode_src = 1'b0;
  logic           realign = 1'b0;
  logic           hs_in = 1'b0;
  logic           vs_in = 1'b0;
  logic [H_W-1:0] len_g = '0;
  logic [H_W-1:0] last_g = '0;
  logic [V_W-1:0] lline = '0;
  logic           hs_out, vs_out;
  logic [H_W-1:0] hc;
  logic [V_W-1:0] vc;

  int vectors = 0;
  int misses  = 0;

  always #4 clk = ~clk;

  line_field_timer #(.H_W(H_W), .V_W(V_W), .HD_WIDTH(HDW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_src_i(mode_src), .realign_i(realign),
    .hsync_i(hs_in), .vsync_i(vs_in), .line_len_gray_i(len_g),
    .last_len_gray_i(last_g), .last_line_i(lline), .hsync_o(hs_out),
    .vsync_o(vs_out), .h_count_o(hc), .v_count_o(vc));

  function automatic logic [H_W-1:0] to_gray(int x);
    logic [H_W-1:0] b;
    b = H_W'(x);
    return b ^ (b >> 1);
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_realign();
    @(negedge clk) realign = 1'b1;
    @(negedge clk) realign = 1'b0;
  endtask

  // R3 R4 R5 R6 R7: full-field sweep, positions computed from the cycle number.
  task automatic run_master(int L, int La, int N, int cycles);
    int p, f, tt, eh, ev;
    len_g = to_gray(L); last_g = to_gray(La); lline = V_W'(N); mode_src = 1'b1;
    do_realign();
    p = L + 4;
    f = N * p + La + 4;
    for (int t = 0; t < cycles; t++) begin
      tt = t % f;
      if (tt < N * p) begin ev = tt / p; eh = tt % p; end
      else begin ev = N; eh = tt - N * p; end
      check("R3/R4 h", int'(hc), eh);
      check("R5 v", int'(vc), ev);
      check("R6 hsync", int'(hs_out), (eh < HDW) ? 1 : 0);
      check("R6 vsync", int'(vs_out), (ev == 0) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int hsave;
    // R1: state during and right after reset.
    repeat (3) @(negedge clk);
    check("R1 h", int'(hc), 0);
    check("R1 v", int'(vc), 0);
    check("R1 hsync", int'(hs_out), 0);
    check("R1 vsync", int'(vs_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 follower hsync", int'(hs_out), 0);
    check("R1 follower vsync", int'(vs_out), 0);

    // R3 R4 R5 R6 R7 sweep.
    for (int L = 0; L < 10; L++)
      for (int k = 0; k < 3; k++)
        for (int N = 0; N < 3; N++) begin
          int La;
          La = (k == 0) ? 0 : (k == 1) ? 2 : 7;
          run_master(L, La, N, 2 * (N * (L + 4) + La + 4) + 2);
        end

    // R2: 1560-clock line programmed as Gray 0x51E (1556).
    check("R2 gray word", int'(to_gray(1556)), 'h51E);
    run_master(1556, 0, 1, 2 * (1560 + 4) + 4);

    // R11: mid-line change keeps the current line at 9 clocks.
    len_g = to_gray(5); last_g = to_gray(5); lline = 4'd3; mode_src = 1'b1;
    do_realign();
    for (int t = 0; t <= 22; t++) begin
      if (t == 2) len_g = to_gray(9);
      if (t < 9)       begin check("R11 h", int'(hc), t);      check("R11 v", int'(vc), 0); end
      else if (t < 22) begin check("R11 h", int'(hc), t - 9);  check("R11 v", int'(vc), 1); end
      else             begin check("R11 h", int'(hc), 0);      check("R11 v", int'(vc), 2); end
      @(negedge clk);
    end

    // R12: mode change waits for the line end (line = 14 clocks).
    len_g = to_gray(10); lline = 4'd2; mode_src = 1'b1;
    do_realign();
    for (int t = 0; t <= 14; t++) begin
      if (t == 3) mode_src = 1'b0;
      if (t == 13) check("R12 still source vsync", int'(vs_out), 1);
      if (t == 14) begin
        check("R12 follower hsync", int'(hs_out), 0);
        check("R12 h", int'(hc), 0);
      end
      @(negedge clk);
    end

    // R8 R9 R10: follower mode.
    len_g = to_gray(200); lline = 4'd5; mode_src = 1'b0;
    do_realign();
    check("R8 hsync", int'(hs_out), 0);
    check("R8 vsync", int'(vs_out), 0);
    repeat (5) @(negedge clk);
    check("R8 h running", int'(hc), 5);
    hs_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 h zero", int'(hc), 0);
    check("R9 v step", int'(vc), 1);
    @(negedge clk);
    check("R9 no retrigger", int'(hc), 1);
    check("R8 hsync low", int'(hs_out), 0);
    hs_in = 1'b0;
    repeat (4) @(negedge clk);
    hs_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 second edge v", int'(vc), 2);
    hs_in = 1'b0;
    repeat (2) @(negedge clk);
    hsave = int'(hc);
    vs_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 v zero", int'(vc), 0);
    check("R10 h kept", int'(hc), hsave + 3);
    check("R8 vsync low", int'(vs_out), 0);
    vs_in = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule